// File: doc/BRIEF.md
# Prefix-Aware Opcode Stream Decoder

This block takes one opcode byte at a time from an 8-bit instruction stream and turns each complete instruction into a control record. The record holds an operation class, an ALU operation, destination and source operand selectors, a branch condition, an interrupt-mode value, and the number of immediate bytes the fetch logic must collect next. The decoder does not execute anything, touch memory, or handle displacements. Its output drives the execute stage.

Some bytes are not instructions on their own. Two index-prefix bytes each pick an index register for the next opcode only. Two escape bytes make the decoder wait for one more byte before it emits a record. While an index prefix is active, the decoder rewrites the high-half, low-half and pair operands to the chosen index register. A byte the decoder does not implement raises a sticky trap that reports the byte and its context. After a trap, input stays blocked until reset.

Top module: `opcode_stream_decoder`

## Requirements
- R1: The bytes 0xDD and 0xFD produce no record. They set the index mode for the next opcode only: 0xDD selects IX and 0xFD selects IY. If a second prefix byte arrives before an opcode, the later one wins. The mode clears once an opcode is decoded, so the following opcode is unprefixed.
- R2: Operand selector codes are 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=memory at HL, 7=A, 8=IXH, 9=IXL, 10=IYH, 11=IYL, 12=BC, 13=DE, 14=HL, 15=SP, 16=IX, 17=IY, 18=immediate, 19=none, 20=memory at IX, 21=memory at IY, 22=absolute address, 23=I/O port. Under IX mode, H, L and HL become 8, 9 and 16. Under IY mode they become 10, 11 and 17.
- R3: When an opcode in the range 0x40–0x7F has a memory operand, the memory pointer follows the index mode (codes 6, 20 or 21). The other 8-bit operand keeps plain H (4) or L (5).
- R4: Bytes 0x40–0x7F decode to class 1 (8-bit load). The destination comes from bits 5:3 and the source from bits 2:0, using the register codes 0–7. The exception is 0x76, which is class 6 (halt) with both selectors set to 19.
- R5: Bytes 0x80–0xBF decode to class 3 (ALU) with destination A. The ALU code is bits 5:3, where 0=ADD, 1=ADC, 2=SUB, 3=SBC, 4=AND, 5=XOR, 6=OR and 7=CP. The source comes from bits 2:0.
- R6: Relative jumps are class 4 and take 1 immediate byte. 0x18 has condition 0 (always). 0x20, 0x28, 0x30 and 0x38 have conditions 1 (Z clear), 2 (Z set), 3 (C clear) and 4 (C set).
- R7: Absolute jumps are class 5 and take 2 immediate bytes. 0xC3 has condition 0. 0xC2 and 0xCA have conditions 1 and 2. 0xD2 and 0xDA have 3 and 4. 0xE2 and 0xEA have 5 (P/V clear) and 6 (P/V set). 0xF2 and 0xFA have 7 (S clear) and 8 (S set).
- R8: 0xCB and 0xED emit no record and consume one more byte. After 0xED, the bytes 0x46, 0x56 and 0x5E give class 9 with interrupt mode 0, 1 and 2.
- R9: The remaining single-byte opcodes decode as follows:
  - 0x00 is class 0.
  - 0x01, 0x11, 0x21 and 0x31 are class 2 with destination BC, DE, HL or SP, source 18 and 2 immediate bytes.
  - 0x06–0x3E with bits 2:0 equal to 110 are class 1 with destination from bits 5:3, source 18 and 1 immediate byte.
  - 0x32 is class 1 with destination 22, source A and 2 immediate bytes.
  - 0xDB is class 10 with destination A, source 23 and 1 immediate byte.
  - 0xF3 is class 7 and 0xFB is class 8.
  - 0xFE is class 3 with ALU code 7, source 18 and 1 immediate byte.
- R10: Any other byte sets a sticky trap and produces no record. The trap reports the offending byte and a context byte: the pending escape byte if there is one, otherwise the active prefix byte, otherwise 0x00. After a trap, input ready stays low until reset.
- R11: A record raises the output valid one cycle after its last byte is accepted. The record holds steady while the downstream is not ready, and input ready is low during that time. Valid drops in the cycle after the record is taken, unless a new record replaces it.
- R12: Reset clears the prefix, the escape, the trap and the output valid, and raises input ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_byte | input | 8 | Opcode stream byte |
| in_valid | input | 1 | Byte present |
| in_ready | output | 1 | Decoder accepts a byte |
| out_valid | output | 1 | Record valid |
| out_ready | input | 1 | Downstream takes the record |
| out_class | output | 4 | Operation class |
| out_alu | output | 3 | ALU operation |
| out_dst | output | 5 | Destination selector |
| out_src | output | 5 | Source selector |
| out_cond | output | 4 | Branch condition |
| out_imm | output | 2 | Immediate bytes to fetch |
| out_mode | output | 2 | Interrupt mode |
| trap | output | 1 | Unimplemented opcode seen (sticky) |
| trap_prefix | output | 8 | Context byte of the trap |
| trap_code | output | 8 | Offending opcode byte |

## Verification
Handing off the held record and accepting the next opcode byte can happen on the same clock edge. The bench provokes this by stalling the downstream with one record pending. It then raises downstream ready in the same cycle that it presents a new byte. It judges the result by checking that the first record stays stable during the stall, that the new record appears the very next cycle without a gap, and that valid then falls after one cycle.

// File: rtl/opcode_stream_decoder.sv
module opcode_stream_decoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_byte,
  input  logic       in_valid,
  output logic       in_ready,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [3:0] out_class,
  output logic [2:0] out_alu,
  output logic [4:0] out_dst,
  output logic [4:0] out_src,
  output logic [3:0] out_cond,
  output logic [1:0] out_imm,
  output logic [1:0] out_mode,
  output logic       trap,
  output logic [7:0] trap_prefix,
  output logic [7:0] trap_code
);
  localparam logic [4:0] S_H = 5'd4, S_L = 5'd5, S_MHL = 5'd6, S_A = 5'd7;
  localparam logic [4:0] S_IXH = 5'd8, S_IXL = 5'd9, S_IYH = 5'd10, S_IYL = 5'd11;
  localparam logic [4:0] S_BC = 5'd12, S_DE = 5'd13, S_HL = 5'd14, S_SP = 5'd15;
  localparam logic [4:0] S_IX = 5'd16, S_IY = 5'd17, S_IMM = 5'd18, S_NONE = 5'd19;
  localparam logic [4:0] S_MIX = 5'd20, S_MIY = 5'd21, S_ABS = 5'd22, S_PORT = 5'd23;

  localparam logic [3:0] C_NOP = 4'd0, C_LD8 = 4'd1, C_LD16 = 4'd2, C_ALU = 4'd3;
  localparam logic [3:0] C_JR = 4'd4, C_JP = 4'd5, C_HALT = 4'd6, C_DI = 4'd7;
  localparam logic [3:0] C_EI = 4'd8, C_IM = 4'd9, C_IN = 4'd10;

  localparam logic [1:0] IDX_NONE = 2'd0, IDX_X = 2'd1, IDX_Y = 2'd2;
  localparam logic [1:0] ESC_NONE = 2'd0, ESC_BIT = 2'd1, ESC_EXT = 2'd2;

  logic [1:0] pfx_q, esc_q;
  logic       take;

  logic [3:0] d_cls;
  logic [2:0] d_alu;
  logic [4:0] d_dst, d_src;
  logic [3:0] d_cond;
  logic [1:0] d_imm, d_mode;
  logic       d_ok;

  assign in_ready = !trap && !(out_valid && !out_ready);
  assign take     = in_valid && in_ready;

  function automatic logic [4:0] reg_sel(input logic [2:0] r, input logic [1:0] p, input logic sub);
    case (r)
      3'd4:    reg_sel = (sub && p == IDX_X) ? S_IXH : (sub && p == IDX_Y) ? S_IYH : S_H;
      3'd5:    reg_sel = (sub && p == IDX_X) ? S_IXL : (sub && p == IDX_Y) ? S_IYL : S_L;
      3'd6:    reg_sel = (p == IDX_X) ? S_MIX : (p == IDX_Y) ? S_MIY : S_MHL;
      default: reg_sel = {2'b00, r};
    endcase
  endfunction

  function automatic logic [4:0] pair_sel(input logic [1:0] q, input logic [1:0] p);
    case (q)
      2'd0:    pair_sel = S_BC;
      2'd1:    pair_sel = S_DE;
      2'd2:    pair_sel = (p == IDX_X) ? S_IX : (p == IDX_Y) ? S_IY : S_HL;
      default: pair_sel = S_SP;
    endcase
  endfunction

  always_comb begin
    logic [2:0] fd, fs;
    fd     = in_byte[5:3];
    fs     = in_byte[2:0];
    d_cls  = C_NOP;
    d_alu  = 3'd0;
    d_dst  = S_NONE;
    d_src  = S_NONE;
    d_cond = 4'd0;
    d_imm  = 2'd0;
    d_mode = 2'd0;
    d_ok   = 1'b0;
    if (esc_q == ESC_BIT) begin
      d_ok = 1'b0;
    end else if (esc_q == ESC_EXT) begin
      d_cls = C_IM;
      case (in_byte)
        8'h46: begin d_ok = 1'b1; d_mode = 2'd0; end
        8'h56: begin d_ok = 1'b1; d_mode = 2'd1; end
        8'h5E: begin d_ok = 1'b1; d_mode = 2'd2; end
        default: d_ok = 1'b0;
      endcase
    end else begin
      case (in_byte[7:6])
        2'b01: begin
          d_ok = 1'b1;
          if (in_byte == 8'h76) d_cls = C_HALT;
          else begin
            d_cls = C_LD8;
            d_dst = reg_sel(fd, pfx_q, !(fd == 3'd6 || fs == 3'd6));
            d_src = reg_sel(fs, pfx_q, !(fd == 3'd6 || fs == 3'd6));
          end
        end
        2'b10: begin
          d_ok  = 1'b1;
          d_cls = C_ALU;
          d_alu = fd;
          d_dst = S_A;
          d_src = reg_sel(fs, pfx_q, 1'b1);
        end
        2'b00: begin
          if (in_byte == 8'h00) d_ok = 1'b1;
          else if (fs == 3'b001 && !in_byte[3]) begin
            d_ok = 1'b1; d_cls = C_LD16; d_dst = pair_sel(in_byte[5:4], pfx_q);
            d_src = S_IMM; d_imm = 2'd2;
          end else if (fs == 3'b110) begin
            d_ok = 1'b1; d_cls = C_LD8; d_dst = reg_sel(fd, pfx_q, 1'b1);
            d_src = S_IMM; d_imm = 2'd1;
          end else if (in_byte == 8'h18) begin
            d_ok = 1'b1; d_cls = C_JR; d_imm = 2'd1;
          end else if (fs == 3'b000 && in_byte[5]) begin
            d_ok = 1'b1; d_cls = C_JR; d_imm = 2'd1;
            d_cond = {2'b00, in_byte[4:3]} + 4'd1;
          end else if (in_byte == 8'h32) begin
            d_ok = 1'b1; d_cls = C_LD8; d_dst = S_ABS; d_src = S_A; d_imm = 2'd2;
          end
        end
        default: begin
          if (in_byte == 8'hC3) begin
            d_ok = 1'b1; d_cls = C_JP; d_imm = 2'd2;
          end else if (fs == 3'b010) begin
            d_ok = 1'b1; d_cls = C_JP; d_imm = 2'd2; d_cond = {1'b0, fd} + 4'd1;
          end else if (in_byte == 8'hDB) begin
            d_ok = 1'b1; d_cls = C_IN; d_dst = S_A; d_src = S_PORT; d_imm = 2'd1;
          end else if (in_byte == 8'hF3) begin
            d_ok = 1'b1; d_cls = C_DI;
          end else if (in_byte == 8'hFB) begin
            d_ok = 1'b1; d_cls = C_EI;
          end else if (in_byte == 8'hFE) begin
            d_ok = 1'b1; d_cls = C_ALU; d_alu = 3'd7; d_dst = S_A; d_src = S_IMM; d_imm = 2'd1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pfx_q       <= IDX_NONE;
      esc_q       <= ESC_NONE;
      out_valid   <= 1'b0;
      out_class   <= C_NOP;
      out_alu     <= 3'd0;
      out_dst     <= S_NONE;
      out_src     <= S_NONE;
      out_cond    <= 4'd0;
      out_imm     <= 2'd0;
      out_mode    <= 2'd0;
      trap        <= 1'b0;
      trap_prefix <= 8'h00;
      trap_code   <= 8'h00;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (take) begin
        if (esc_q == ESC_NONE && (in_byte == 8'hDD || in_byte == 8'hFD)) begin
          pfx_q <= (in_byte == 8'hDD) ? IDX_X : IDX_Y;
        end else if (esc_q == ESC_NONE && (in_byte == 8'hCB || in_byte == 8'hED)) begin
          esc_q <= (in_byte == 8'hCB) ? ESC_BIT : ESC_EXT;
        end else begin
          pfx_q <= IDX_NONE;
          esc_q <= ESC_NONE;
          if (d_ok) begin
            out_valid <= 1'b1;
            out_class <= d_cls;
            out_alu   <= d_alu;
            out_dst   <= d_dst;
            out_src   <= d_src;
            out_cond  <= d_cond;
            out_imm   <= d_imm;
            out_mode  <= d_mode;
          end else begin
            trap        <= 1'b1;
            trap_code   <= in_byte;
            trap_prefix <= (esc_q == ESC_BIT) ? 8'hCB :
                           (esc_q == ESC_EXT) ? 8'hED :
                           (pfx_q == IDX_X)   ? 8'hDD :
                           (pfx_q == IDX_Y)   ? 8'hFD : 8'h00;
          end
        end
      end
    end
  end
endmodule

module opcode_stream_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] in_byte,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [3:0] out_class,
  input logic [4:0] out_dst,
  input logic [4:0] out_src,
  input logic       trap,
  input logic [7:0] trap_code,
  input logic [1:0] esc
);
  logic acc;
  assign acc = in_valid && in_ready;

  // R1
  prefix_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && esc == 2'd0 && (in_byte == 8'hDD || in_byte == 8'hFD) |=> !out_valid);

  // R8
  escape_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && esc == 2'd0 && (in_byte == 8'hCB || in_byte == 8'hED) |=> !out_valid);

  // R3
  plain_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == 4'd1 && (out_src == 5'd20 || out_src == 5'd21 ||
      out_dst == 5'd20 || out_dst == 5'd21) |-> (out_dst < 5'd8 || out_dst > 5'd11) &&
      (out_src < 5'd8 || out_src > 5'd11));

  // R10
  trap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> trap && $stable(trap_code));

  // R10
  trap_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> !in_ready);

  // R11
  hold_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_class) && $stable(out_dst) && $stable(out_src));

  // R11
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

bind opcode_stream_decoder opcode_stream_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_class(out_class), .out_dst(out_dst),
  .out_src(out_src), .trap(trap), .trap_code(trap_code), .esc(esc_q)
);

// File: tb/opcode_stream_decoder_test.sv
`timescale 1ns/1ps
module opcode_stream_decoder_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] in_byte;
  logic       in_valid;
  logic       in_ready;
  logic       out_valid;
  logic       out_ready;
  logic [3:0] out_class;
  logic [2:0] out_alu;
  logic [4:0] out_dst, out_src;
  logic [3:0] out_cond;
  logic [1:0] out_imm, out_mode;
  logic       trap;
  logic [7:0] trap_prefix, trap_code;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  opcode_stream_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_class(out_class), .out_alu(out_alu),
    .out_dst(out_dst), .out_src(out_src), .out_cond(out_cond), .out_imm(out_imm),
    .out_mode(out_mode), .trap(trap), .trap_prefix(trap_prefix), .trap_code(trap_code)
  );

  localparam int NV = 34;
  // {lead, opcode, class, alu, dst, src, cond, imm, mode}
  localparam logic [40:0] VEC [NV] = '{
    {8'h00, 8'h00, 4'd0, 3'd0, 5'd19, 5'd19, 4'd0, 2'd0, 2'd0},
    {8'h00, 8'h41, 4'd1, 3'd0, 5'd0,  5'd1,  4'd0, 2'd0, 2'd0},
    {8'hDD, 8'h44, 4'd1, 3'd0, 5'd0,  5'd8,  4'd0, 2'd0, 2'd0},
    {8'hFD, 8'h6D, 4'd1, 3'd0, 5'd11, 5'd11, 4'd0, 2'd0, 2'd0},
    {8'hDD, 8'h66, 4'd1, 3'd0, 5'd4,  5'd20, 4'd0, 2'd0, 2'd0},
    {8'hFD, 8'h75, 4'd1, 3'd0, 5'd21, 5'd5,  4'd0, 2'd0, 2'd0},
    {8'hDD, 8'h6E, 4'd1, 3'd0, 5'd5,  5'd20, 4'd0, 2'd0, 2'd0},
    {8'hDD, 8'h70, 4'd1, 3'd0, 5'd20, 5'd0,  4'd0, 2'd0, 2'd0},
    {8'h00, 8'h76, 4'd6, 3'd0, 5'd19, 5'd19, 4'd0, 2'd0, 2'd0},
    {8'h00, 8'h9E, 4'd3, 3'd3, 5'd7,  5'd6,  4'd0, 2'd0, 2'd0},
    {8'hFD, 8'hAC, 4'd3, 3'd5, 5'd7,  5'd10, 4'd0, 2'd0, 2'd0},
    {8'hDD, 8'h84, 4'd3, 3'd0, 5'd7,  5'd8,  4'd0, 2'd0, 2'd0},
    {8'h00, 8'hFE, 4'd3, 3'd7, 5'd7,  5'd18, 4'd0, 2'd1, 2'd0},
    {8'hDD, 8'h21, 4'd2, 3'd0, 5'd16, 5'd18, 4'd0, 2'd2, 2'd0},
    {8'h00, 8'h31, 4'd2, 3'd0, 5'd15, 5'd18, 4'd0, 2'd2, 2'd0},
    {8'h00, 8'h11, 4'd2, 3'd0, 5'd13, 5'd18, 4'd0, 2'd2, 2'd0},
    {8'hFD, 8'h26, 4'd1, 3'd0, 5'd10, 5'd18, 4'd0, 2'd1, 2'd0},
    {8'hDD, 8'h36, 4'd1, 3'd0, 5'd20, 5'd18, 4'd0, 2'd1, 2'd0},
    {8'h00, 8'h3E, 4'd1, 3'd0, 5'd7,  5'd18, 4'd0, 2'd1, 2'd0},
    {8'h00, 8'h32, 4'd1, 3'd0, 5'd22, 5'd7,  4'd0, 2'd2, 2'd0},
    {8'h00, 8'hDB, 4'd10, 3'd0, 5'd7, 5'd23, 4'd0, 2'd1, 2'd0},
    {8'h00, 8'h18, 4'd4, 3'd0, 5'd19, 5'd19, 4'd0, 2'd1, 2'd0},
    {8'h00, 8'h20, 4'd4, 3'd0, 5'd19, 5'd19, 4'd1, 2'd1, 2'd0},
    {8'h00, 8'h38, 4'd4, 3'd0, 5'd19, 5'd19, 4'd4, 2'd1, 2'd0},
    {8'h00, 8'hC3, 4'd5, 3'd0, 5'd19, 5'd19, 4'd0, 2'd2, 2'd0},
    {8'h00, 8'hCA, 4'd5, 3'd0, 5'd19, 5'd19, 4'd2, 2'd2, 2'd0},
    {8'h00, 8'hEA, 4'd5, 3'd0, 5'd19, 5'd19, 4'd6, 2'd2, 2'd0},
    {8'h00, 8'hFA, 4'd5, 3'd0, 5'd19, 5'd19, 4'd8, 2'd2, 2'd0},
    {8'hED, 8'h5E, 4'd9, 3'd0, 5'd19, 5'd19, 4'd0, 2'd0, 2'd2},
    {8'hED, 8'h46, 4'd9, 3'd0, 5'd19, 5'd19, 4'd0, 2'd0, 2'd0},
    {8'h00, 8'hF3, 4'd7, 3'd0, 5'd19, 5'd19, 4'd0, 2'd0, 2'd0},
    {8'h00, 8'hFB, 4'd8, 3'd0, 5'd19, 5'd19, 4'd0, 2'd0, 2'd0},
    {8'hDD, 8'h00, 4'd0, 3'd0, 5'd19, 5'd19, 4'd0, 2'd0, 2'd0},
    {8'h00, 8'h44, 4'd1, 3'd0, 5'd0,  5'd4,  4'd0, 2'd0, 2'd0}
  };

  function automatic string tag_of(input logic [40:0] v);
    logic idx;
    idx = (v[40:33] == 8'hDD || v[40:33] == 8'hFD);
    if (idx && (v[17:13] == 5'd20 || v[17:13] == 5'd21 || v[12:8] == 5'd20 || v[12:8] == 5'd21)) return "R3";
    if (idx) return "R2";
    if (v[32:31] == 2'b01) return "R4";
    if (v[32:31] == 2'b10) return "R5";
    if (v[24:21] == 4'd4) return "R6";
    if (v[24:21] == 4'd5) return "R7";
    if (v[24:21] == 4'd9) return "R8";
    return "R9";
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    in_byte  = b;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [24:0] rec();
    return {out_class, out_alu, out_dst, out_src, out_cond, out_imm, out_mode};
  endfunction

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!out_valid && !trap && in_ready, "R12", {out_valid, trap, in_ready}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40:33] != 8'h00) begin
        send(VEC[i][40:33]);
        chk(!out_valid, (VEC[i][40:33] == 8'hED) ? "R8" : "R1", out_valid, 0);
      end
      send(VEC[i][32:25]);
      chk(out_valid && rec() == VEC[i][24:0], tag_of(VEC[i]), {out_valid, rec()}, {1'b1, VEC[i][24:0]});
      @(negedge clk);
      chk(!out_valid, "R11", out_valid, 0);
    end

    // R1 later prefix wins
    send(8'hDD); send(8'hFD); send(8'h7C);
    chk(out_valid && out_dst == 5'd7 && out_src == 5'd10, "R1", {out_dst, out_src}, {5'd7, 5'd10});
    @(negedge clk);

    // R11 stall, then handoff and acceptance on the same edge
    out_ready = 1'b0;
    send(8'h00);
    chk(out_valid && !in_ready, "R11", {out_valid, in_ready}, 2'b10);
    @(negedge clk);
    chk(out_valid && !in_ready && out_class == 4'd0, "R11", {out_valid, in_ready, out_class}, 6'b100000);
    out_ready = 1'b1;
    send(8'hF3);
    chk(out_valid && out_class == 4'd7, "R11", {out_valid, out_class}, {1'b1, 4'd7});
    @(negedge clk);
    chk(!out_valid, "R11", out_valid, 0);

    // R10 trap under prefix
    send(8'hDD); send(8'h02);
    chk(trap && trap_prefix == 8'hDD && trap_code == 8'h02, "R10", {trap, trap_prefix, trap_code}, {1'b1, 8'hDD, 8'h02});
    chk(!in_ready && !out_valid, "R10", {in_ready, out_valid}, 0);
    in_byte = 8'h00; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    chk(!out_valid && trap && trap_code == 8'h02, "R10", {out_valid, trap, trap_code}, {1'b0, 1'b1, 8'h02});
    rst_n = 1'b0;
    @(negedge clk);
    chk(!trap && !out_valid && in_ready, "R12", {trap, out_valid, in_ready}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 prefix cleared by reset
    send(8'hDD);
    do_reset();
    send(8'h65);
    chk(out_valid && out_dst == 5'd4 && out_src == 5'd5, "R12", {out_dst, out_src}, {5'd4, 5'd5});
    @(negedge clk);

    // R8 extended escape with unknown byte
    send(8'hED);
    chk(!out_valid, "R8", out_valid, 0);
    send(8'h47);
    chk(trap && trap_prefix == 8'hED && trap_code == 8'h47, "R10", {trap, trap_prefix, trap_code}, {1'b1, 8'hED, 8'h47});
    do_reset();
    send(8'hCB); send(8'h00);
    chk(trap && trap_prefix == 8'hCB && trap_code == 8'h00, "R10", {trap, trap_prefix, trap_code}, {1'b1, 8'hCB, 8'h00});
    do_reset();
    send(8'h08);
    chk(trap && trap_prefix == 8'h00 && trap_code == 8'h08, "R10", {trap, trap_prefix, trap_code}, {1'b1, 8'h00, 8'h08});
    do_reset();
    send(8'hED); send(8'h56);
    chk(out_valid && out_class == 4'd9 && out_mode == 2'd1, "R8", {out_class, out_mode}, {4'd9, 2'd1});
    @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule